// File: doc/BRIEF.md
# Secure RTC Lifecycle Sequencer

This block keeps the trust lifecycle of a low-power real-time-clock domain. After reset the domain sits in an init state. The host must first load a fixed magic word into a glitch-detector register. It then writes a control word that leaves init for a non-valid state, and a second control word that reaches the valid state. Each completed exit leaves a sticky flag in the status view. Time keeping is allowed only in the valid state, or, when the external 2-bit security mode input selects low security, as soon as the enable bit is set.

Once the domain is valid, any tamper pulse, power-glitch pulse or loss of the magic word moves it to a failure state. It also raises a security-violation bit in the control register. Only a software reset clears this. Three registers sit behind a simple single-cycle write port and a registered read port: control at address 0, status at address 1 and the glitch word at address 2. Two exit-status flags, each with its own enable, drive one interrupt line.

Top module: `rtc_lifecycle_seq`

## Requirements
- R1: After reset the state is init (00), control reads 0, the glitch word reads 0, status reads only bit1 set plus the security mode in bits 11:10, and `count_en` and `irq` are 0.
- R2: In init, with the glitch word armed, a control write with bit15 (init exit request) and bit11 (non-secure access) set moves the state to non-valid (01) and sets status bit15. The state appears on `state_o` and in status bits 13:12, encoded 00 init, 01 non-valid, 10 valid, 11 failure.
- R3: While the glitch word differs from 0x41736166, no control write leaves init.
- R4: In non-valid, a control write with bits 15, 14, 11 and 3 all set, while status bit15 is set and the glitch word is armed, moves the state to valid (10) and sets status bit14.
- R5: The non-valid exit request has no effect outside the non-valid state or while status bit15 is clear.
- R6: The glitch word reads back as written. Status bit1 is set in every cycle where the word differs from 0x41736166, and by a `glitch_evt` pulse.
- R7: Writing 1 to status bits 1, 2, 14 or 15 clears that bit, and writing all ones clears all of them. A flag set in the same cycle as its clear stays set.
- R8: A `tamper_evt` pulse sets status bit2 in any state.
- R9: In valid, a tamper pulse, a glitch pulse or an unarmed glitch word moves the state to failure (11) and sets control bit10. Failure holds until a software reset.
- R10: A control write with bit0 set returns the state to init and clears control, the glitch word and status bits 2, 14 and 15, leaving bit1 set. Bit0 always reads 0.
- R11: `count_en` is 1 when control bit3 is set and the state is valid. It is also 1 when control bit3 is set, the security mode is low (00) and the state is not failure. It changes on the same edge as the state.
- R12: `irq` equals (status bit15 AND control bit13) OR (status bit14 AND control bit12), and it is registered on the same edge as the flags.
- R13: Status bits 11:10 show `sec_mode`. Control bit10 cannot be written by the host.
- R14: `rd_data` shows, one cycle after `rd_addr` is presented, the register contents as they stood before that edge. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 status, 2 glitch word |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data |
| sec_mode | input | 2 | Security mode: 0 low, 1 medium, 2 high, 3 reserved |
| tamper_evt | input | 1 | Clock-tamper event pulse |
| glitch_evt | input | 1 | Power-glitch event pulse |
| state_o | output | 2 | Current lifecycle state |
| count_en | output | 1 | Time keeping permitted |
| irq | output | 1 | Exit-status interrupt |

## Verification
A hardware event can arrive in the same cycle as a host write-1-to-clear of the bit it sets. The bench provokes this by raising `tamper_evt` in the valid state during the very cycle that writes 1 to status bit2. That one edge must both enter failure and leave bit2 set. Set-over-clear priority is judged by reading status afterwards and by the per-cycle model, which keeps the flag set. The same approach covers a glitch word that is re-armed during the clear of bit1, where the clear must then take effect.

// File: rtl/rtc_lc_pkg.sv
package rtc_lc_pkg;

  typedef enum logic [1:0] {
    LC_INIT     = 2'b00,
    LC_NONVALID = 2'b01,
    LC_VALID    = 2'b10,
    LC_FAIL     = 2'b11
  } lc_state_e;

  // control bit positions
  localparam int C_SWR     = 0;
  localparam int C_EN      = 3;
  localparam int C_SV      = 10;
  localparam int C_NSA     = 11;
  localparam int C_NVX_IE  = 12;
  localparam int C_INX_IE  = 13;
  localparam int C_NVX_REQ = 14;
  localparam int C_INX_REQ = 15;

  // status bit positions
  localparam int S_PGD      = 1;
  localparam int S_CTD      = 2;
  localparam int S_MODE_LO  = 10;
  localparam int S_STATE_LO = 12;
  localparam int S_NVX      = 14;
  localparam int S_INX      = 15;

  // sticky flag indices
  localparam int F_PGD  = 0;
  localparam int F_CTD  = 1;
  localparam int F_INX  = 2;
  localparam int F_NVX  = 3;
  localparam int NFLAGS = 4;

  // register addresses
  localparam int A_CTRL   = 0;
  localparam int A_STAT   = 1;
  localparam int A_GLITCH = 2;

  localparam logic [1:0] MODE_LOW = 2'b00;

endpackage

// File: rtl/rtc_lc_flags.sv
module rtc_lc_flags #(
  parameter int NF = 4,
  parameter logic [NF-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swr,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flag_q,
  output logic [NF-1:0] flag_d
);

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_comb begin
      if (swr) flag_d[i] = RST_VAL[i];
      else     flag_d[i] = (flag_q[i] & ~clr_i[i]) | set_i[i];
    end

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= RST_VAL[i];
      else     flag_q[i] <= flag_d[i];
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (set_i[i] && !swr) |=> flag_q[i]);
  end

endmodule

// File: rtl/rtc_lc_fsm.sv
module rtc_lc_fsm
  import rtc_lc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      swr,
  input  logic      init_cmd,
  input  logic      nv_cmd,
  input  logic      armed,
  input  logic      inx_flag,
  input  logic      fault_evt,
  output lc_state_e state_q,
  output lc_state_e state_d,
  output logic      inx_set,
  output logic      nvx_set,
  output logic      sv_set
);

  always_comb begin
    state_d = state_q;
    inx_set = 1'b0;
    nvx_set = 1'b0;
    sv_set  = 1'b0;
    if (swr) begin
      state_d = LC_INIT;
    end else begin
      unique case (state_q)
        LC_INIT: if (init_cmd && armed) begin
          state_d = LC_NONVALID;
          inx_set = 1'b1;
        end
        LC_NONVALID: if (nv_cmd && armed && inx_flag) begin
          state_d = LC_VALID;
          nvx_set = 1'b1;
        end
        LC_VALID: if (fault_evt) begin
          state_d = LC_FAIL;
          sv_set  = 1'b1;
        end
        default: state_d = LC_FAIL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LC_INIT;
    else     state_q <= state_d;
  end

  // R9
  fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == LC_FAIL && !swr) |=> state_q == LC_FAIL);
  // R10
  swr_init_chk: assert property (@(posedge clk) disable iff (rst)
    swr |=> state_q == LC_INIT);
  // R5
  init_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == LC_INIT && !swr) |=> (state_q == LC_INIT || state_q == LC_NONVALID));
  // R5
  nv_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == LC_NONVALID && !inx_flag) |=> state_q != LC_VALID);
  // R3
  unarmed_init_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == LC_INIT && !armed) |=> state_q == LC_INIT);

endmodule

// File: rtl/rtc_lifecycle_seq.sv
module rtc_lifecycle_seq
  import rtc_lc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int CTRL_W = 16,
  parameter logic [DATA_W-1:0] GLITCH_MAGIC = 32'h41736166
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        sec_mode,
  input  logic              tamper_evt,
  input  logic              glitch_evt,
  output logic [1:0]        state_o,
  output logic              count_en,
  output logic              irq
);

  localparam int PAD_W = DATA_W - CTRL_W;
  localparam logic [NFLAGS-1:0] FLAG_RST = NFLAGS'(1) << F_PGD;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] glitch_q, glitch_d;
  logic [DATA_W-1:0] stat_w;
  logic [NFLAGS-1:0] flag_q, flag_d, flag_set, flag_clr;
  logic              wr_ctrl, wr_stat, wr_glt, swr;
  logic              init_cmd, nv_cmd, armed_q, armed_d, fault_evt;
  logic              inx_set, nvx_set, sv_set;
  lc_state_e         state_q, state_d;

  // write decode
  assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign wr_stat  = wr_en && (wr_addr == ADDR_W'(A_STAT));
  assign wr_glt   = wr_en && (wr_addr == ADDR_W'(A_GLITCH));
  assign swr      = wr_ctrl && wr_data[C_SWR];
  assign init_cmd = wr_ctrl && wr_data[C_INX_REQ] && wr_data[C_NSA];
  assign nv_cmd   = init_cmd && wr_data[C_NVX_REQ] && wr_data[C_EN];

  // glitch word
  always_comb begin
    if (swr)         glitch_d = '0;
    else if (wr_glt) glitch_d = wr_data;
    else             glitch_d = glitch_q;
  end
  assign armed_q   = (glitch_q == GLITCH_MAGIC);
  assign armed_d   = (glitch_d == GLITCH_MAGIC);
  assign fault_evt = tamper_evt | glitch_evt | ~armed_q;

  rtc_lc_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .swr       (swr),
    .init_cmd  (init_cmd),
    .nv_cmd    (nv_cmd),
    .armed     (armed_q),
    .inx_flag  (flag_q[F_INX]),
    .fault_evt (fault_evt),
    .state_q   (state_q),
    .state_d   (state_d),
    .inx_set   (inx_set),
    .nvx_set   (nvx_set),
    .sv_set    (sv_set)
  );

  // sticky flags
  always_comb begin
    flag_set        = '0;
    flag_set[F_PGD] = glitch_evt | ~armed_d;
    flag_set[F_CTD] = tamper_evt;
    flag_set[F_INX] = inx_set;
    flag_set[F_NVX] = nvx_set;
    flag_clr        = '0;
    if (wr_stat) begin
      flag_clr[F_PGD] = wr_data[S_PGD];
      flag_clr[F_CTD] = wr_data[S_CTD];
      flag_clr[F_INX] = wr_data[S_INX];
      flag_clr[F_NVX] = wr_data[S_NVX];
    end
  end

  rtc_lc_flags #(.NF(NFLAGS), .RST_VAL(FLAG_RST)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .swr    (swr),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_q (flag_q),
    .flag_d (flag_d)
  );

  // control register: bit0 self-clears, bit10 is set by hardware only
  always_comb begin
    ctrl_d = ctrl_q;
    if (swr) begin
      ctrl_d = '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_d        = wr_data[CTRL_W-1:0];
        ctrl_d[C_SWR] = 1'b0;
        ctrl_d[C_SV]  = ctrl_q[C_SV];
      end
      if (sv_set) ctrl_d[C_SV] = 1'b1;
    end
  end

  // status view
  always_comb begin
    stat_w                      = '0;
    stat_w[S_PGD]               = flag_q[F_PGD];
    stat_w[S_CTD]               = flag_q[F_CTD];
    stat_w[S_MODE_LO +: 2]      = sec_mode;
    stat_w[S_STATE_LO +: 2]     = state_q;
    stat_w[S_NVX]               = flag_q[F_NVX];
    stat_w[S_INX]               = flag_q[F_INX];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      glitch_q <= '0;
      rd_data  <= '0;
      count_en <= 1'b0;
      irq      <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      glitch_q <= glitch_d;
      unique case (rd_addr)
        ADDR_W'(A_CTRL):   rd_data <= {{PAD_W{1'b0}}, ctrl_q};
        ADDR_W'(A_STAT):   rd_data <= stat_w;
        ADDR_W'(A_GLITCH): rd_data <= glitch_q;
        default:           rd_data <= '0;
      endcase
      count_en <= ctrl_d[C_EN] &&
                  (state_d == LC_VALID ||
                   (sec_mode == MODE_LOW && state_d != LC_FAIL));
      irq      <= (flag_d[F_INX] & ctrl_d[C_INX_IE]) |
                  (flag_d[F_NVX] & ctrl_d[C_NVX_IE]);
    end
  end

  assign state_o = state_q;

  // R11
  fail_no_count_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == LC_FAIL) |-> !count_en);
  // R13
  sv_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[C_SV] && !swr) |=> ctrl_q[C_SV]);
  // R12
  irq_map_chk: assert property (@(posedge clk) disable iff (rst)
    irq == ((flag_q[F_INX] && ctrl_q[C_INX_IE]) || (flag_q[F_NVX] && ctrl_q[C_NVX_IE])));
  // R4
  valid_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == LC_VALID && $past(state_q) == LC_NONVALID) |-> flag_q[F_NVX]);
  // R10
  swr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    swr |=> (ctrl_q == '0 && glitch_q == '0));

endmodule

// File: tb/rtc_lifecycle_seq_tb_top.sv
module rtc_lifecycle_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MAGIC = 32'h41736166;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  sec_mode = 2'b10;
  logic        tamper_evt = 1'b0;
  logic        glitch_evt = 1'b0;
  logic [1:0]  state_o;
  logic        count_en;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_lifecycle_seq dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sec_mode(sec_mode),
    .tamper_evt(tamper_evt), .glitch_evt(glitch_evt),
    .state_o(state_o), .count_en(count_en), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int          m_state;
  logic [15:0] m_ctrl;
  logic [31:0] m_glt, m_rd;
  bit          m_pgd, m_ctd, m_ies, m_nves, m_cnt, m_irq;

  function automatic logic [31:0] m_status();
    logic [31:0] s = 0;
    s[1] = m_pgd; s[2] = m_ctd;
    s[11:10] = sec_mode;
    s[13:12] = 2'(m_state);
    s[14] = m_nves; s[15] = m_ies;
    return s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_ctrl = 0; m_glt = 0; m_rd = 0;
      m_pgd = 1; m_ctd = 0; m_ies = 0; m_nves = 0; m_cnt = 0; m_irq = 0;
    end else begin
      bit          cw, sw, gw, swr, armed, fault, set_i, set_n, set_v;
      logic [31:0] clr;
      case (rd_addr)
        2'd0: m_rd = {16'h0, m_ctrl};
        2'd1: m_rd = m_status();
        2'd2: m_rd = m_glt;
        default: m_rd = 0;
      endcase
      cw = wr_en && wr_addr == 2'd0;
      sw = wr_en && wr_addr == 2'd1;
      gw = wr_en && wr_addr == 2'd2;
      swr = cw && wr_data[0];
      armed = (m_glt == MAGIC);
      fault = tamper_evt || glitch_evt || !armed;
      if (swr) begin
        m_state = 0; m_ctrl = 0; m_glt = 0;
        m_pgd = 1; m_ctd = 0; m_ies = 0; m_nves = 0;
      end else begin
        set_i = 0; set_n = 0; set_v = 0;
        if (m_state == 0 && cw && wr_data[15] && wr_data[11] && armed) begin
          m_state = 1; set_i = 1;
        end else if (m_state == 1 && cw && wr_data[15] && wr_data[14] &&
                     wr_data[11] && wr_data[3] && m_ies && armed) begin
          m_state = 2; set_n = 1;
        end else if (m_state == 2 && fault) begin
          m_state = 3; set_v = 1;
        end
        if (gw) m_glt = wr_data;
        clr = sw ? wr_data : 32'h0;
        m_pgd  = (m_pgd && !clr[1]) || glitch_evt || (m_glt != MAGIC);
        m_ctd  = (m_ctd && !clr[2]) || tamper_evt;
        m_ies  = (m_ies && !clr[15]) || set_i;
        m_nves = (m_nves && !clr[14]) || set_n;
        if (cw) m_ctrl = (wr_data[15:0] & 16'hFBFE) | (m_ctrl & 16'h0400);
        if (set_v) m_ctrl[10] = 1'b1;
      end
      m_cnt = m_ctrl[3] && (m_state == 2 || (sec_mode == 2'b00 && m_state != 3));
      m_irq = (m_ies && m_ctrl[13]) || (m_nves && m_ctrl[12]);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 state_o vs model", 32'(state_o), 32'(m_state));
      check("R11 count_en vs model", 32'(count_en), 32'(m_cnt));
      check("R12 irq vs model", 32'(irq), 32'(m_irq));
      check("R14 rd_data vs model", rd_data, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd_expect(input logic [1:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    check(tag, rd_data, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R1 to R14 run) actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check("R1 reset state", 32'(state_o), 32'h0);
    check("R1 reset count_en", 32'(count_en), 32'h0);
    check("R1 reset irq", 32'(irq), 32'h0);
    rd_expect(2'd0, 32'h0000, "R1 reset control");
    rd_expect(2'd1, 32'h0802, "R1 reset status");
    rd_expect(2'd2, 32'h0, "R1 reset glitch word");

    // init exit refused while unarmed
    wr(2'd0, 32'h8800);
    check("R3 unarmed init exit refused", 32'(state_o), 32'h0);

    // arm and clear all flags
    wr(2'd2, MAGIC);
    rd_expect(2'd2, MAGIC, "R6 glitch word readback");
    wr(2'd1, 32'hFFFF_FFFF);
    rd_expect(2'd1, 32'h0800, "R7 all-ones clear");

    // non-valid request in init ignored; enable without valid in high mode
    wr(2'd0, 32'h4008);
    check("R5 nv request in init ignored", 32'(state_o), 32'h0);
    check("R11 enable in high mode not valid", 32'(count_en), 32'h0);

    // init exit
    wr(2'd0, 32'hA800);
    check("R2 init exit to non-valid", 32'(state_o), 32'h1);
    check("R12 irq from init exit", 32'(irq), 32'h1);
    rd_expect(2'd1, 32'h9800, "R2 init exit status");

    // clear init flag, then non-valid exit must be refused
    wr(2'd1, 32'h8000);
    check("R12 irq drops after clear", 32'(irq), 32'h0);
    wr(2'd0, 32'hC808);
    check("R5 nv exit refused without init flag", 32'(state_o), 32'h1);
    rd_expect(2'd1, 32'h1800, "R7 init flag cleared");

    // software reset
    wr(2'd0, 32'h0001);
    check("R10 swr to init", 32'(state_o), 32'h0);
    rd_expect(2'd0, 32'h0, "R10 control cleared");
    rd_expect(2'd2, 32'h0, "R10 glitch word cleared");
    rd_expect(2'd1, 32'h0802, "R10 status after swr");

    // full sequence to valid
    wr(2'd2, MAGIC);
    wr(2'd1, 32'h2);
    wr(2'd0, 32'h8800);
    wr(2'd0, 32'hD808);
    check("R4 non-valid exit to valid", 32'(state_o), 32'h2);
    check("R11 counting in valid", 32'(count_en), 32'h1);
    check("R12 irq from nv exit", 32'(irq), 32'h1);
    rd_expect(2'd1, 32'hE800, "R4 valid status");

    // tamper in the same cycle as its own clear
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h4; tamper_evt = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; tamper_evt = 1'b0;
    check("R9 tamper in valid enters failure", 32'(state_o), 32'h3);
    check("R11 no counting in failure", 32'(count_en), 32'h0);
    rd_expect(2'd1, 32'hF804, "R7 set wins over clear");
    rd_expect(2'd0, 32'hDC08, "R9 violation bit set");
    wr(2'd0, 32'h0008);
    rd_expect(2'd0, 32'h0408, "R13 violation bit not writable");
    check("R9 failure held", 32'(state_o), 32'h3);

    // back to init, low-security bypass
    wr(2'd0, 32'h0001);
    check("R10 swr leaves failure", 32'(state_o), 32'h0);
    sec_mode = 2'b00;
    wr(2'd0, 32'h0008);
    check("R11 low mode enable counts", 32'(count_en), 32'h1);
    rd_expect(2'd1, 32'h0002, "R13 security mode in status");
    rd_expect(2'd3, 32'h0, "R14 unused address reads zero");

    // event pulses
    wr(2'd2, MAGIC);
    wr(2'd1, 32'h2);
    rd_expect(2'd1, 32'h0000, "R6 armed word clears glitch flag");
    glitch_evt = 1'b1;
    @(negedge clk);
    glitch_evt = 1'b0;
    rd_expect(2'd1, 32'h0002, "R6 glitch pulse sets flag");
    tamper_evt = 1'b1;
    @(negedge clk);
    tamper_evt = 1'b0;
    rd_expect(2'd1, 32'h0006, "R8 tamper pulse in init");
    check("R8 init state unaffected", 32'(state_o), 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule